// File: doc/BRIEF.md
# Bubble-Tolerant Thermometer-to-Binary Encoder

This block sits behind the comparator bank of an N-bit parallel (flash) converter. It takes 2^N-1 comparator decisions as one thermometer word and returns the N-bit binary count of the level that the input crossed. Comparator offsets and timing skew can leave stray bits (bubbles) in that word. To keep them from producing a false boundary, every boundary cell looks at three neighbouring bits and fires only on a one-one-zero pattern. A plain one-zero edge is not enough to fire a cell.

The boundary cells form a one-hot word. A ROM-style encoder ORs the index of every asserted cell into the output. If several cells assert, their indices combine bitwise.

A static mode pin can switch in a 3-of-5 majority filter ahead of the boundary cells. This filter tolerates any single bubble, at any position, to within one code. The comparator word is registered on the sample clock, and so is the binary result. The block delivers one code per sample clock.

Top module: `therm_bin_encoder`

## Requirements
- R1: `comp_i[i-1]` is the decision of comparator i (i = 1 .. 2^N-1). A clean thermometer word has ones in bits 0..k-1 and zeros above them. Such a word yields code k in both modes.
- R2: A comparator word present at rising edge E appears on `code_o` just after edge E+1. A new word is accepted on every edge.
- R3: `rst` is synchronous and active high. At a reset edge, `code_o` goes to 0 and the captured comparator word is cleared. The first edge after release therefore still gives 0, and the next edge gives the code of the new word.
- R4: Comparator 0 is virtual and reads 1, and so does the virtual position below it. Position 2^N reads 0, and in majority mode position 2^N+1 reads 0 as well. So an all-zero word gives 0 and an all-one word gives 2^N-1.
- R5: With `majority_en`=0, a word is a clean code k with one extra 1 at comparator j, where j >= k+2. That word gives code k.
- R6: With `majority_en`=0, a clean code k (k >= 1) whose top one (comparator k) reads 0 gives k-1. The correction leans toward the lower code.
- R7: With `majority_en`=0, a clean code k (k >= 3) whose comparator k-2 reads 0 fires two boundary cells. The output is the bitwise OR (k-3)|k.
- R8: With `majority_en`=1, each bit is replaced by the 3-of-5 majority of itself and its two neighbours on each side, with the padding of R4. Any single flipped bit in a clean code k then gives a code within one of k.
- R9: With `majority_en`=1, a clean code k is left unchanged in two cases: a 1 cleared at comparator j <= k-3, or a 1 set at comparator j >= k+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| majority_en | input | 1 | Static mode: 0 three-tap detect, 1 majority filter then detect |
| comp_i | input | 2^N-1 | Comparator decisions, bit i-1 for comparator i |
| code_o | output | N | Registered binary code |

## Verification
The hardest case to reach is two boundary cells firing at once, because the OR result depends on which cells fire. The stimulus gets there by clearing a bit two below the top of a clean code. It also applies every single-bit flip to every clean code in both modes. For each pattern the bench works out the expected code from the bubble position relative to the true edge. A separate streaming run and a mid-stream reset pin down the two-register latency.

// File: rtl/tbe_pkg.sv
package tbe_pkg;

  // 3-of-5 majority: true when at least three inputs are high
  function automatic logic maj5(input logic [4:0] w);
    logic [2:0] sum;
    sum = 3'(w[0]) + 3'(w[1]) + 3'(w[2]) + 3'(w[3]) + 3'(w[4]);
    return sum >= 3'd3;
  endfunction

  // Three-tap boundary cell: two ones below, a zero above
  function automatic logic edge3(input logic lo2, input logic lo1, input logic hi);
    return lo2 & lo1 & ~hi;
  endfunction

endpackage

// File: rtl/tbe_vote.sv
module tbe_vote #(
  parameter int M = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] raw_i,
  output logic [M-1:0] filt_o
);
  import tbe_pkg::*;

  // padded view: two forced ones below, two forced zeros above
  logic [M+3:0] pad;
  assign pad = {2'b00, raw_i, 2'b11};

  for (genvar g = 0; g < M; g++) begin : g_cell
    assign filt_o[g] = maj5(pad[g+4:g]);
  end

  logic raw_clean;
  assign raw_clean = ((raw_i + 1'b1) & raw_i) == '0;

  AST_MAJ_KEEPS_THERM: assert property (@(posedge clk) disable iff (rst)
    raw_clean |-> (filt_o == raw_i)); // R8
endmodule

// File: rtl/tbe_boundary.sv
module tbe_boundary #(
  parameter int M = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M-1:0] therm_i,
  output logic [M:0]   hit_o
);
  import tbe_pkg::*;

  // p[k+1] holds position k; p[0] = position -1, p[M+2] = position M+1
  logic [M+2:0] p;
  assign p = {1'b0, therm_i, 2'b11};

  for (genvar k = 0; k <= M; k++) begin : g_cell
    assign hit_o[k] = edge3(p[k], p[k+1], p[k+2]);
  end

  logic therm_clean;
  assign therm_clean = ((therm_i + 1'b1) & therm_i) == '0;

  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (rst)
    therm_clean |-> $onehot(hit_o)); // R1
  AST_HIT_PRESENT: assert property (@(posedge clk) disable iff (rst)
    $countones(hit_o) >= 1); // R4
endmodule

// File: rtl/tbe_or_encoder.sv
module tbe_or_encoder #(
  parameter int N = 4,
  parameter int M = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [M:0]   hit_i,
  output logic [N-1:0] bin_o
);
  // column of the ROM: which rows carry a one in output bit b
  function automatic logic [M:0] col_mask(input int b);
    logic [M:0] m;
    for (int k = 0; k <= M; k++) m[k] = ((k >> b) & 1) == 1;
    return m;
  endfunction

  for (genvar b = 0; b < N; b++) begin : g_col
    localparam logic [M:0] MASK = col_mask(b);
    assign bin_o[b] = |(hit_i & MASK);
  end

  AST_ENC_SELECTS: assert property (@(posedge clk) disable iff (rst)
    $onehot(hit_i) |-> hit_i[bin_o]); // R7
endmodule

// File: rtl/therm_bin_encoder.sv
module therm_bin_encoder #(
  parameter int N = 4,
  localparam int M = (1 << N) - 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         majority_en,
  input  logic [M-1:0] comp_i,
  output logic [N-1:0] code_o
);
  logic [M-1:0] comp_q;
  logic [M-1:0] filt;
  logic [M-1:0] sel;
  logic [M:0]   hit;
  logic [N-1:0] enc;

  always_ff @(posedge clk) begin
    if (rst) comp_q <= '0;
    else     comp_q <= comp_i;
  end

  tbe_vote #(.M(M)) u_vote (
    .clk(clk), .rst(rst), .raw_i(comp_q), .filt_o(filt)
  );

  assign sel = majority_en ? filt : comp_q;

  tbe_boundary #(.M(M)) u_bnd (
    .clk(clk), .rst(rst), .therm_i(sel), .hit_o(hit)
  );

  tbe_or_encoder #(.N(N), .M(M)) u_enc (
    .clk(clk), .rst(rst), .hit_i(hit), .bin_o(enc)
  );

  always_ff @(posedge clk) begin
    if (rst) code_o <= '0;
    else     code_o <= enc;
  end

  logic q_clean;
  assign q_clean = ((comp_q + 1'b1) & comp_q) == '0;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (code_o == '0)); // R3
  AST_CLEAN_CODE: assert property (@(posedge clk) disable iff (rst)
    q_clean |=> (int'(code_o) == $past($countones(comp_q)))); // R2
endmodule

// File: tb/therm_bin_encoder_tb.sv
module therm_bin_encoder_tb;
  localparam int N = 4;
  localparam int M = (1 << N) - 1;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic majority_en = 1'b0;
  logic [M-1:0] comp = '0;
  logic [N-1:0] code;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  therm_bin_encoder #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .majority_en(majority_en), .comp_i(comp), .code_o(code)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [M-1:0] therm(input int k);
    logic [M-1:0] v;
    for (int i = 0; i < M; i++) v[i] = (i < k);
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input int act, input int exp);
    int d;
    checks++;
    d = act - exp;
    if (d > 1 || d < -1) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d+-1", req, act, exp);
    end
  endtask

  task automatic convert(input logic [M-1:0] v, output int got);
    @(negedge clk) comp = v;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) got = int'(code);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int got;
    int ks [20];
    // reset state (R3)
    repeat (3) @(negedge clk);
    check("R3 reset output", int'(code), 0);

    // R3: mid-stream reset clears both stages
    rst = 1'b0;
    convert({M{1'b1}}, got);
    check("R4 all ones", got, M);
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R3 output cleared", int'(code), 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R3 first edge after release", int'(code), 0);
    @(negedge clk);
    check("R3 second edge after release", int'(code), M);

    convert('0, got);
    check("R4 all zeros", got, 0);

    // R2: streaming, one new word per edge
    for (int n = 0; n < 20; n++) ks[n] = (n * 7 + 3) % (M + 1);
    for (int n = 0; n < 22; n++) begin
      @(negedge clk);
      if (n >= 2) check("R2 stream latency", int'(code), ks[n-2]);
      if (n < 20) comp = therm(ks[n]);
    end

    for (int mode = 0; mode < 2; mode++) begin
      majority_en = mode[0];
      // R1: clean codes in both modes
      for (int k = 0; k <= M; k++) begin
        convert(therm(k), got);
        check("R1 clean code", got, k);
      end
    end

    majority_en = 1'b0;
    // R5: lone sparkle above the edge
    for (int k = 0; k <= M - 2; k++)
      for (int j = k + 2; j <= M; j++) begin
        convert(therm(k) | (M'(1) << (j - 1)), got);
        check("R5 sparkle ignored", got, k);
      end
    // R6: top one dropped
    for (int k = 1; k <= M; k++) begin
      convert(therm(k) & ~(M'(1) << (k - 1)), got);
      check("R6 biased low", got, k - 1);
    end
    // R7: two boundaries OR together
    for (int k = 3; k <= M; k++) begin
      convert(therm(k) & ~(M'(1) << (k - 3)), got);
      check("R7 OR combine", got, (k - 3) | k);
    end

    majority_en = 1'b1;
    // R8 / R9: every single flip of every clean code
    for (int k = 0; k <= M; k++)
      for (int j = 1; j <= M; j++) begin
        convert(therm(k) ^ (M'(1) << (j - 1)), got);
        check_near("R8 majority within one", got, k);
        if ((j <= k - 3) || (j >= k + 4))
          check("R9 far bubble exact", got, k);
      end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule